// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block steers operands around the register file in a five-stage, eight-register in-order pipeline. While an instruction sits in decode, each of its two source specifiers is compared against the destination of every older instruction still in flight. There are four such producers: the instruction in execute, the one in the memory stage, the one in writeback, and a holding register that keeps the result retired one cycle earlier. The register file only shows a written value to decode reads one cycle after the write, so the holding register is a genuine producer. Each of the four matches is kept separate. The youngest match picks a source tag, which is registered as the instruction moves into execute. In execute the tag drives the operand multiplexers. Because the pipeline remembers which later position will supply the value, decode finishes without waiting.

There is one case where forwarding cannot help. A load in execute whose destination is read by the instruction directly behind it raises a stall request. The surrounding pipeline then holds fetch and decode and sends a no-op into execute. The block itself loads a register-file select for that bubble. The pipeline advances every cycle that stall is low. The block has no data stream of its own, so every pin is a plain control or data level with no handshake.

Top module: `opnd_bypass`

## Requirements
- R1: Reset (rst_n low, asynchronous) forces both execute selects to 0 (register file), and stall stays low when no load is in execute, so each operand equals the value carried with the instruction (ex_rfa, ex_rfb).
- R2: Select codes are 0 register file, 1 memory-stage result, 2 writeback result, 3 holding-register value, 4 value captured at decode. Opcodes are add 0, nand 1, lw 2, sw 3, beq 4, jalr 5, halt 6, noop 7. When no producer matches, an operand comes from the register file.
- R3: A source matching the destination of a non-load writer in execute during decode gets select 1 in the next cycle and takes the memory-stage ALU result, with no stall.
- R4: A source matching the memory-stage destination gets select 2 in the next cycle and takes the writeback value: the memory read data when the writeback opcode is lw, the ALU result otherwise.
- R5: A source matching the writeback destination gets select 3 in the next cycle and takes the holding-register value of that cycle.
- R6: A source matching the holding-register destination gets select 4, which is the holding-register value sampled in the decode cycle.
- R7: When several producers match one source, the youngest wins, in the order execute, memory, writeback, holding register.
- R8: Producers with opcode sw, beq, noop or halt never match.
- R9: A lw in execute whose destination equals a source the decode instruction uses raises stall in that cycle. The following cycle's selects are 0. The re-decoded instruction then receives the load data through select 2.
- R10: Sources an opcode does not read never match or stall. Add, nand, sw and beq read both specifiers. Lw and jalr read only the first. Noop and halt read none.
- R11: For sw the second (data) operand is forwarded like any other source.
- R12: The two operands resolve independently and may take different producers in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_op | input | 3 | Opcode in decode |
| dec_ra | input | $clog2(NREG) | First source specifier in decode |
| dec_rb | input | $clog2(NREG) | Second source specifier in decode |
| ex_op | input | 3 | Opcode in execute |
| ex_dst | input | $clog2(NREG) | Destination in execute |
| ex_rfa | input | DW | First operand as read from the register file, carried into execute |
| ex_rfb | input | DW | Second operand as read from the register file, carried into execute |
| exm_op | input | 3 | Opcode in memory stage |
| exm_dst | input | $clog2(NREG) | Destination in memory stage |
| exm_alu | input | DW | ALU result in memory stage |
| mwb_op | input | 3 | Opcode in writeback |
| mwb_dst | input | $clog2(NREG) | Destination in writeback |
| mwb_alu | input | DW | ALU result in writeback |
| mwb_mdata | input | DW | Memory read data in writeback |
| hold_op | input | 3 | Opcode of the most recently retired instruction |
| hold_dst | input | $clog2(NREG) | Destination of the most recently retired instruction |
| hold_val | input | DW | Value retired in the previous cycle |
| stall | output | 1 | Load-use hold request |
| sel_a | output | 3 | First operand source select in execute |
| sel_b | output | 3 | Second operand source select in execute |
| opa | output | DW | First operand delivered to execute |
| opb | output | DW | Second operand delivered to execute |

## Verification
On every cycle the assertions check several cycle-to-cycle relations. A stall is only ever requested for a load in execute. Each stall is followed by a register-file bubble. An execute-stage bypass never points at a load, and it always traces back to a writing producer whose destination matched the source one cycle earlier. A load's unused second specifier never stalls. The bench scenarios cover what needs chosen data values: that each select delivers the right value, that memory data is preferred for loads, that the youngest producer wins, that each operand resolves on its own, and that a stalled consumer gets the load data on re-decode.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_NAND = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_JALR = 3'd5,
    OP_HALT = 3'd6,
    OP_NOOP = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    SRC_RF   = 3'd0,
    SRC_EXM  = 3'd1,
    SRC_MWB  = 3'd2,
    SRC_HOLD = 3'd3,
    SRC_CAP  = 3'd4
  } src_e;

  // Instruction writes a register
  function automatic logic op_writes(op_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_LW) || (op == OP_JALR);
  endfunction

  // Instruction reads its first source specifier
  function automatic logic op_reads_a(op_e op);
    return (op != OP_NOOP) && (op != OP_HALT);
  endfunction

  // Instruction reads its second source specifier (sw: store data)
  function automatic logic op_reads_b(op_e op);
    return (op == OP_ADD) || (op == OP_NAND) || (op == OP_SW) || (op == OP_BEQ);
  endfunction

endpackage

// File: rtl/bypass_match.sv
// Decode-time comparison of one source against all in-flight producers.
// Index 0 is the youngest producer (execute), NPROD-1 the oldest.
module bypass_match
  import opnd_bypass_pkg::*;
#(
  parameter int RW    = 3,
  parameter int NPROD = 4
) (
  input  logic                      reads_i,
  input  logic [RW-1:0]             src_i,
  input  logic [NPROD-1:0][RW-1:0]  pdst_i,
  input  logic [NPROD-1:0]          pwr_i,
  input  logic                      young_load_i,
  output src_e                      nsel_o,
  output logic                      lu_o
);

  logic [NPROD-1:0] hit;

  always_comb begin
    for (int i = 0; i < NPROD; i++) begin
      hit[i] = reads_i && pwr_i[i] && (pdst_i[i] == src_i);
    end
  end

  // Oldest first, younger hits overwrite: youngest wins
  always_comb begin
    nsel_o = SRC_RF;
    for (int i = NPROD - 1; i >= 0; i--) begin
      if (hit[i]) nsel_o = src_e'(3'(i + 1));
    end
  end

  assign lu_o = hit[0] && young_load_i;

endmodule

// File: rtl/bypass_sel_reg.sv
// Carries the chosen source tag from decode into execute, plus a private
// copy of the holding value for the oldest bypass path.
module bypass_sel_reg
  import opnd_bypass_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          stall_i,
  input  src_e          nsel_i,
  input  logic [DW-1:0] hold_val_i,
  output src_e          sel_o,
  output logic [DW-1:0] cap_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_o <= SRC_RF;
      cap_o <= '0;
    end else if (stall_i) begin
      sel_o <= SRC_RF;
    end else begin
      sel_o <= nsel_i;
      if (nsel_i == SRC_CAP) cap_o <= hold_val_i;
    end
  end

endmodule

// File: rtl/bypass_opmux.sv
module bypass_opmux
  import opnd_bypass_pkg::*;
#(
  parameter int DW = 32
) (
  input  src_e          sel_i,
  input  logic [DW-1:0] rf_i,
  input  logic [DW-1:0] exm_i,
  input  logic [DW-1:0] mwb_i,
  input  logic [DW-1:0] hold_i,
  input  logic [DW-1:0] cap_i,
  output logic [DW-1:0] val_o
);

  always_comb begin
    unique case (sel_i)
      SRC_EXM:  val_o = exm_i;
      SRC_MWB:  val_o = mwb_i;
      SRC_HOLD: val_o = hold_i;
      SRC_CAP:  val_o = cap_i;
      default:  val_o = rf_i;
    endcase
  end

endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
  import opnd_bypass_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int RW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    dec_op,
  input  logic [RW-1:0] dec_ra,
  input  logic [RW-1:0] dec_rb,
  input  logic [2:0]    ex_op,
  input  logic [RW-1:0] ex_dst,
  input  logic [DW-1:0] ex_rfa,
  input  logic [DW-1:0] ex_rfb,
  input  logic [2:0]    exm_op,
  input  logic [RW-1:0] exm_dst,
  input  logic [DW-1:0] exm_alu,
  input  logic [2:0]    mwb_op,
  input  logic [RW-1:0] mwb_dst,
  input  logic [DW-1:0] mwb_alu,
  input  logic [DW-1:0] mwb_mdata,
  input  logic [2:0]    hold_op,
  input  logic [RW-1:0] hold_dst,
  input  logic [DW-1:0] hold_val,
  output logic          stall,
  output logic [2:0]    sel_a,
  output logic [2:0]    sel_b,
  output logic [DW-1:0] opa,
  output logic [DW-1:0] opb
);

  localparam int NPROD = 4;
  localparam int NOPND = 2;

  logic [NPROD-1:0][RW-1:0] pdst;
  logic [NPROD-1:0]         pwr;
  logic [NOPND-1:0][RW-1:0] src;
  logic [NOPND-1:0]         reads;
  logic [NOPND-1:0][DW-1:0] rfv;
  logic [NOPND-1:0][DW-1:0] opv;
  logic [NOPND-1:0]         lu;
  src_e                     nsel [NOPND];
  src_e                     sel  [NOPND];
  logic [DW-1:0]            cap  [NOPND];
  logic [DW-1:0]            mwb_res;
  logic                     young_load;

  assign pdst = {hold_dst, mwb_dst, exm_dst, ex_dst};
  assign pwr  = {op_writes(op_e'(hold_op)), op_writes(op_e'(mwb_op)),
                 op_writes(op_e'(exm_op)),  op_writes(op_e'(ex_op))};

  assign src   = {dec_rb, dec_ra};
  assign reads = {op_reads_b(op_e'(dec_op)), op_reads_a(op_e'(dec_op))};
  assign rfv   = {ex_rfb, ex_rfa};

  assign young_load = (op_e'(ex_op) == OP_LW);
  assign mwb_res    = (op_e'(mwb_op) == OP_LW) ? mwb_mdata : mwb_alu;

  for (genvar k = 0; k < NOPND; k++) begin : g_opnd
    bypass_match #(.RW(RW), .NPROD(NPROD)) u_match (
      .reads_i      (reads[k]),
      .src_i        (src[k]),
      .pdst_i       (pdst),
      .pwr_i        (pwr),
      .young_load_i (young_load),
      .nsel_o       (nsel[k]),
      .lu_o         (lu[k])
    );

    bypass_sel_reg #(.DW(DW)) u_sreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .stall_i    (stall),
      .nsel_i     (nsel[k]),
      .hold_val_i (hold_val),
      .sel_o      (sel[k]),
      .cap_o      (cap[k])
    );

    bypass_opmux #(.DW(DW)) u_mux (
      .sel_i  (sel[k]),
      .rf_i   (rfv[k]),
      .exm_i  (exm_alu),
      .mwb_i  (mwb_res),
      .hold_i (hold_val),
      .cap_i  (cap[k]),
      .val_o  (opv[k])
    );
  end

  assign stall = |lu;
  assign sel_a = sel[0];
  assign sel_b = sel[1];
  assign opa   = opv[0];
  assign opb   = opv[1];

endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk
  import opnd_bypass_pkg::*;
#(
  parameter int RW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    dec_op,
  input logic [RW-1:0] dec_ra,
  input logic [RW-1:0] dec_rb,
  input logic [2:0]    ex_op,
  input logic [RW-1:0] ex_dst,
  input logic [2:0]    exm_op,
  input logic          stall,
  input logic [2:0]    sel_a,
  input logic [2:0]    sel_b
);

  // R9: a stall sends a register-file bubble into execute
  a_r9_bubble_after_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> (sel_a == 3'd0) && (sel_b == 3'd0));

  // R9: only a load in execute can request a hold
  a_r9_stall_needs_load: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (op_e'(ex_op) == OP_LW));

  // R3: the execute-stage bypass never targets a load
  a_r3_exm_not_load: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 3'd1) |-> (op_e'(exm_op) != OP_LW));

  // R3 / R8: the execute-stage bypass traces back to a writing producer matched at decode
  a_r8_exm_origin: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_a == 3'd1) |-> ($past(ex_dst) == $past(dec_ra)) && !$past(stall)
                        && op_writes(op_e'($past(ex_op))));

  // R10: a load's unread second specifier never holds the pipeline
  a_r10_lw_b_unused: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_e'(dec_op) == OP_LW) && (op_e'(ex_op) == OP_LW) &&
     (ex_dst == dec_rb) && (ex_dst != dec_ra)) |-> !stall);

endmodule

bind opnd_bypass opnd_bypass_chk #(.RW(RW)) u_opnd_bypass_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .dec_op (dec_op),
  .dec_ra (dec_ra),
  .dec_rb (dec_rb),
  .ex_op  (ex_op),
  .ex_dst (ex_dst),
  .exm_op (exm_op),
  .stall  (stall),
  .sel_a  (sel_a),
  .sel_b  (sel_b)
);

// File: tb/test_opnd_bypass.sv
module test_opnd_bypass;

  localparam int DW = 32;
  localparam logic [2:0] ADD = 3'd0, NAND = 3'd1, LW = 3'd2, SW = 3'd3,
                         BEQ = 3'd4, HALT = 3'd6, NOP = 3'd7;

  typedef struct packed {
    logic [3:0] req;
    logic [2:0] dop, ra, rb, xop, xd, mop, md, wop, wd, hop, hd;
    logic [2:0] ea, eb;
    logic       es;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    //   req  dop   ra    rb    xop   xd    mop   md    wop   wd    hop   hd    ea    eb   es
    '{4'd2,  ADD,  3'd3, 3'd4, NOP,  3'd3, NOP,  3'd3, NOP,  3'd4, NOP,  3'd3, 3'd0, 3'd0, 1'b0}, // R2
    '{4'd3,  ADD,  3'd3, 3'd4, ADD,  3'd3, NOP,  3'd0, NOP,  3'd0, NOP,  3'd0, 3'd1, 3'd0, 1'b0}, // R3
    '{4'd4,  ADD,  3'd3, 3'd4, NOP,  3'd0, ADD,  3'd4, NOP,  3'd0, NOP,  3'd0, 3'd0, 3'd2, 1'b0}, // R4 alu
    '{4'd4,  NAND, 3'd3, 3'd4, NOP,  3'd0, LW,   3'd3, NOP,  3'd0, NOP,  3'd0, 3'd2, 3'd0, 1'b0}, // R4 load data
    '{4'd5,  ADD,  3'd3, 3'd4, NOP,  3'd0, NOP,  3'd0, NAND, 3'd3, NOP,  3'd0, 3'd3, 3'd0, 1'b0}, // R5
    '{4'd6,  ADD,  3'd3, 3'd4, NOP,  3'd0, NOP,  3'd0, NOP,  3'd0, ADD,  3'd4, 3'd0, 3'd4, 1'b0}, // R6
    '{4'd7,  ADD,  3'd3, 3'd4, ADD,  3'd3, ADD,  3'd3, ADD,  3'd3, ADD,  3'd3, 3'd1, 3'd0, 1'b0}, // R7
    '{4'd7,  ADD,  3'd3, 3'd4, NOP,  3'd0, NAND, 3'd3, ADD,  3'd3, ADD,  3'd3, 3'd2, 3'd0, 1'b0}, // R7
    '{4'd8,  ADD,  3'd3, 3'd4, SW,   3'd3, BEQ,  3'd3, NOP,  3'd3, HALT, 3'd3, 3'd0, 3'd0, 1'b0}, // R8
    '{4'd9,  ADD,  3'd3, 3'd4, LW,   3'd3, NOP,  3'd0, NOP,  3'd0, NOP,  3'd0, 3'd0, 3'd0, 1'b1}, // R9
    '{4'd10, LW,   3'd5, 3'd3, LW,   3'd3, NOP,  3'd0, NOP,  3'd0, NOP,  3'd0, 3'd0, 3'd0, 1'b0}, // R10
    '{4'd11, SW,   3'd5, 3'd3, ADD,  3'd3, NOP,  3'd0, NOP,  3'd0, NOP,  3'd0, 3'd0, 3'd1, 1'b0}, // R11
    '{4'd12, NAND, 3'd3, 3'd4, ADD,  3'd4, NOP,  3'd0, ADD,  3'd3, NOP,  3'd0, 3'd3, 3'd1, 1'b0}, // R12
    '{4'd9,  BEQ,  3'd2, 3'd3, LW,   3'd3, NOP,  3'd0, NOP,  3'd0, NOP,  3'd0, 3'd0, 3'd0, 1'b1}  // R9 second operand
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] dec_op, ex_op, exm_op, mwb_op, hold_op;
  logic [2:0] dec_ra, dec_rb, ex_dst, exm_dst, mwb_dst, hold_dst;
  logic [DW-1:0] ex_rfa, ex_rfb, exm_alu, mwb_alu, mwb_mdata, hold_val;
  logic stall;
  logic [2:0] sel_a, sel_b;
  logic [DW-1:0] opa, opb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  opnd_bypass #(.DW(DW), .NREG(8)) i_opnd_bypass (
    .clk(clk), .rst_n(rst_n),
    .dec_op(dec_op), .dec_ra(dec_ra), .dec_rb(dec_rb),
    .ex_op(ex_op), .ex_dst(ex_dst), .ex_rfa(ex_rfa), .ex_rfb(ex_rfb),
    .exm_op(exm_op), .exm_dst(exm_dst), .exm_alu(exm_alu),
    .mwb_op(mwb_op), .mwb_dst(mwb_dst), .mwb_alu(mwb_alu), .mwb_mdata(mwb_mdata),
    .hold_op(hold_op), .hold_dst(hold_dst), .hold_val(hold_val),
    .stall(stall), .sel_a(sel_a), .sel_b(sel_b), .opa(opa), .opb(opb)
  );

  task automatic chk(input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Fixed execute-cycle values: rf a/b 100/200, mem-stage ALU 300,
  // writeback ALU 400 / load data 500, holding value 600; decode-cycle holding value 700
  function automatic logic [DW-1:0] expect_val(input logic [2:0] code, input bit is_b,
                                               input bit mwb_load);
    case (code)
      3'd1:    return 32'd300;
      3'd2:    return mwb_load ? 32'd500 : 32'd400;
      3'd3:    return 32'd600;
      3'd4:    return 32'd700;
      default: return is_b ? 32'd200 : 32'd100;
    endcase
  endfunction

  task automatic idle();
    dec_op = NOP; dec_ra = 3'd0; dec_rb = 3'd0;
    ex_op = NOP; ex_dst = 3'd0; exm_op = NOP; exm_dst = 3'd0;
    mwb_op = NOP; mwb_dst = 3'd0; hold_op = NOP; hold_dst = 3'd0;
    ex_rfa = 32'd100; ex_rfb = 32'd200; exm_alu = 32'd300;
    mwb_alu = 32'd400; mwb_mdata = 32'd500; hold_val = 32'd600;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    #1;
    // R1: reset state
    chk("R1", "stall", {31'd0, stall}, 32'd0);
    chk("R1", "sel_a", {29'd0, sel_a}, 32'd0);
    chk("R1", "sel_b", {29'd0, sel_b}, 32'd0);
    chk("R1", "opa", opa, 32'd100);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      string tag;
      v = VEC[n];
      tag = $sformatf("R%0d", v.req);
      @(negedge clk);
      idle();
      dec_op = v.dop; dec_ra = v.ra; dec_rb = v.rb;
      ex_op = v.xop; ex_dst = v.xd; exm_op = v.mop; exm_dst = v.md;
      mwb_op = v.wop; mwb_dst = v.wd; hold_op = v.hop; hold_dst = v.hd;
      hold_val = 32'd700;
      #1 chk(tag, "stall", {31'd0, stall}, {31'd0, v.es});
      @(negedge clk);
      idle();
      mwb_op = v.mop;
      #1;
      chk(tag, "sel_a", {29'd0, sel_a}, {29'd0, v.ea});
      chk(tag, "opa", opa, expect_val(v.ea, 1'b0, v.mop == LW));
      chk(tag, "opb", opb, expect_val(v.eb, 1'b1, v.mop == LW));
    end

    // R9: stall, bubble, then load data reaches the re-decoded consumer
    @(negedge clk);
    idle();
    dec_op = ADD; dec_ra = 3'd3; dec_rb = 3'd4; ex_op = LW; ex_dst = 3'd3;
    #1 chk("R9", "stall on load-use", {31'd0, stall}, 32'd1);
    @(negedge clk);
    idle();
    dec_op = ADD; dec_ra = 3'd3; dec_rb = 3'd4; exm_op = LW; exm_dst = 3'd3;
    #1;
    chk("R9", "stall released", {31'd0, stall}, 32'd0);
    chk("R9", "bubble sel_a", {29'd0, sel_a}, 32'd0);
    chk("R9", "bubble opa", opa, 32'd100);
    @(negedge clk);
    idle();
    mwb_op = LW; mwb_mdata = 32'd555;
    #1;
    chk("R9", "sel_a after stall", {29'd0, sel_a}, 32'd2);
    chk("R9", "opa load data", opa, 32'd555);

    // R1: asynchronous reset clears a pending bypass select
    @(negedge clk);
    idle();
    dec_op = ADD; dec_ra = 3'd6; dec_rb = 3'd6; ex_op = ADD; ex_dst = 3'd6;
    @(negedge clk);
    idle();
    #1 chk("R1", "sel_a before reset", {29'd0, sel_a}, 32'd1);
    rst_n = 1'b0;
    #1;
    chk("R1", "sel_a in reset", {29'd0, sel_a}, 32'd0);
    chk("R1", "sel_b in reset", {29'd0, sel_b}, 32'd0);
    chk("R1", "opb in reset", opb, 32'd200);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule